// File: doc/BRIEF.md
# Edge and Quadrature Counter Core

This block is the counting engine of a timer. It receives two asynchronous external channels, A and B. Each channel passes through a synchronizer, and the block then detects rising and falling edges on the synchronized value. The counter then works in one of two ways:

- **Single-input mode:** the counter increments on the selected edges of channel A.
- **Encoder mode:** the counter moves up or down on edges of either channel. The level of the opposite channel decides the direction.

A two-bit edge select sets which edges count. In encoder mode it gives one, two or four counts per full quadrature cycle.

The count runs from 0 to a ceiling given on an input port and wraps in both directions. A run input gates counting. When run is low the count is cleared and stays at zero. A direction flag reports whether the last counting event went up or down. Register access and clock prescaling belong to the surrounding timer, not to this block.

Top module: `edge_quad_counter`

## Requirements
- R1: After reset `count_o` is 0 and `dir_down_o` is 0.
- R2: Single-input mode (`enc_mode_i`=0) behaves as follows:
  - `count_o` rises by one for each selected edge of `chan_a_i`.
  - `chan_b_i` has no effect.
  - A change on a channel input shows up on `count_o` three rising clock edges after the change.
- R3: Edge select `edge_sel_i` encodings are 00 = rising, 01 = falling, 10 or 11 = both. In encoder mode with rising edges selected:
  - A rising edge on A counts down when B is high and up when B is low.
  - A rising edge on B counts up when A is high and down when A is low.
  - Falling edges do not count.
- R4: In encoder mode with falling edges selected:
  - A falling edge on A counts up when B is high and down when B is low.
  - A falling edge on B counts down when A is high and up when A is low.
  - Rising edges do not count.
- R5: In encoder mode with both edges selected, all the rules of R3 and R4 apply. A full forward quadrature cycle therefore adds 4.
- R6: Counting up from a value at or above `ceiling_i` gives 0.
- R7: Counting down from 0 gives `ceiling_i`.
- R8: In encoder mode, if A and B both change between the same two clock samples, the event is discarded and the count is unchanged.
- R9: While `run_i` is low:
  - `count_o` is 0 one clock after the low level is sampled, and stays 0.
  - Edges are ignored.
  - `dir_down_o` holds its value.
- R10: After a counting event, `dir_down_o` is 1 if the event counted down and 0 if it counted up. Single-input events are up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable; low clears the count |
| enc_mode_i | input | 1 | 1 = encoder mode, 0 = single-input mode |
| edge_sel_i | input | 2 | Active edge select: 00 rising, 01 falling, 1x both |
| ceiling_i | input | CNT_W | Wrap value of the count |
| chan_a_i | input | 1 | External channel A (asynchronous) |
| chan_b_i | input | 1 | External channel B (asynchronous) |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | Direction of the last counting event, 1 = down |

## Verification
The assertions assume the following about the inputs:
- The mode, edge select and ceiling are changed only while `run_i` is low.
- Channel levels are clean digital values once they reach the clock domain.

On that basis, every counted step is a unit step or a wrap. A collision of A and B is predicted from the raw inputs, counting two register stages ahead.

The stimulus keeps within these assumptions:
- Configuration is changed only inside a stopped phase.
- Each channel change is held for three clocks, so the synchronizer pipeline settles before the next change.
- Some changes deliberately flip both channels together to exercise the discard rule.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic lvl;
  } chan_evt_t;
endpackage

// File: rtl/eqc_sync.sv
module eqc_sync #(
  parameter int STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_i,
  output eqc_pkg::chan_evt_t  evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      dly_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      dly_q  <= sync_q[STAGES-1];
    end
  end

  assign evt_o.lvl  = sync_q[STAGES-1];
  assign evt_o.rise = sync_q[STAGES-1] & ~dly_q;
  assign evt_o.fall = ~sync_q[STAGES-1] & dly_q;
endmodule

// File: rtl/eqc_step_decode.sv
module eqc_step_decode (
  input  logic               enc_mode_i,
  input  logic [1:0]         edge_sel_i,
  input  eqc_pkg::chan_evt_t evt_a_i,
  input  eqc_pkg::chan_evt_t evt_b_i,
  output logic               step_vld_o,
  output logic               step_down_o
);
  import eqc_pkg::*;

  logic rise_en, fall_en;
  logic a_hit, b_hit, a_chg, b_chg, a_dn, b_dn;

  assign rise_en = (edge_sel_e'(edge_sel_i) != EDGE_FALL);
  assign fall_en = (edge_sel_e'(edge_sel_i) != EDGE_RISE);

  assign a_hit = (evt_a_i.rise & rise_en) | (evt_a_i.fall & fall_en);
  assign b_hit = (evt_b_i.rise & rise_en) | (evt_b_i.fall & fall_en);
  assign a_chg = evt_a_i.rise | evt_a_i.fall;
  assign b_chg = evt_b_i.rise | evt_b_i.fall;

  // Direction from the opposite channel's synchronized level
  assign a_dn = evt_a_i.rise ? evt_b_i.lvl : ~evt_b_i.lvl;
  assign b_dn = evt_b_i.rise ? ~evt_a_i.lvl : evt_a_i.lvl;

  always_comb begin
    step_vld_o  = 1'b0;
    step_down_o = 1'b0;
    if (!enc_mode_i) begin
      step_vld_o = a_hit;
    end else if (a_chg && b_chg) begin
      step_vld_o = 1'b0;  // collision: discard
    end else if (a_hit) begin
      step_vld_o  = 1'b1;
      step_down_o = a_dn;
    end else if (b_hit) begin
      step_vld_o  = 1'b1;
      step_down_o = b_dn;
    end
  end
endmodule

// File: rtl/eqc_count_reg.sv
module eqc_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_vld_i,
  input  logic             step_down_i,
  input  logic [CNT_W-1:0] ceiling_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (step_vld_i) begin
      dir_q <= step_down_i;
      if (step_down_i) cnt_q <= (cnt_q == '0) ? ceiling_i : cnt_q - ONE;
      else             cnt_q <= (cnt_q >= ceiling_i) ? '0 : cnt_q + ONE;
    end
  end

  assign count_o    = cnt_q;
  assign dir_down_o = dir_q;
endmodule

// File: rtl/edge_quad_counter.sv
module edge_quad_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             enc_mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [CNT_W-1:0] ceiling_i,
  input  logic             chan_a_i,
  input  logic             chan_b_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o
);
  import eqc_pkg::*;

  localparam int NCH = 2;

  logic      [NCH-1:0] raw;
  chan_evt_t           evt [NCH];
  logic                step_vld, step_down;

  assign raw = {chan_b_i, chan_a_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    eqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (raw[c]),
      .evt_o (evt[c])
    );
  end

  eqc_step_decode u_dec (
    .enc_mode_i (enc_mode_i),
    .edge_sel_i (edge_sel_i),
    .evt_a_i    (evt[0]),
    .evt_b_i    (evt[1]),
    .step_vld_o (step_vld),
    .step_down_o(step_down)
  );

  eqc_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .step_vld_i (step_vld),
    .step_down_i(step_down),
    .ceiling_i  (ceiling_i),
    .count_o    (count_o),
    .dir_down_o (dir_down_o)
  );
endmodule

// File: rtl/eqc_checker.sv
module eqc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             enc_mode_i,
  input logic [CNT_W-1:0] ceiling_i,
  input logic             chan_a_i,
  input logic             chan_b_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_down_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic       a_q, b_q;
  logic [1:0] coll_sr;

  // Raw-input collision predictor, aligned to the step it will produce
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      coll_sr <= '0;
    end else begin
      a_q     <= chan_a_i;
      b_q     <= chan_b_i;
      coll_sr <= {coll_sr[0], (chan_a_i != a_q) && (chan_b_i != b_q)};
    end
  end

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_o == '0);

  p_idle_dir_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(dir_down_o));

  p_single_up_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !enc_mode_i) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + ONE || count_o == '0));

  p_step_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (count_o == $past(count_o)) ||
      (dir_down_o ? (count_o == $past(count_o) - ONE ||
                     ($past(count_o) == '0 && count_o == $past(ceiling_i)))
                  : (count_o == $past(count_o) + ONE || count_o == '0)));

  p_collision_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_sr[1] && run_i && enc_mode_i) |=> count_o == $past(count_o));
endmodule

bind edge_quad_counter eqc_checker #(.CNT_W(CNT_W)) u_eqc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .enc_mode_i(enc_mode_i),
  .ceiling_i (ceiling_i),
  .chan_a_i  (chan_a_i),
  .chan_b_i  (chan_b_i),
  .count_o   (count_o),
  .dir_down_o(dir_down_o)
);

// File: tb/tb_edge_quad_counter.sv
module tb_edge_quad_counter;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0, enc = 1'b0, a = 1'b0, b = 1'b0;
  logic [1:0]   pol = 2'b00;
  logic [W-1:0] ceil = '1;
  logic [W-1:0] count;
  logic         dir_dn;

  logic [W-1:0] ecnt = '0;
  logic         edir = 1'b0;
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #2 clk = ~clk;

  edge_quad_counter #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .enc_mode_i(enc),
    .edge_sel_i(pol), .ceiling_i(ceil), .chan_a_i(a), .chan_b_i(b),
    .count_o(count), .dir_down_o(dir_dn)
  );

  task automatic chk(input string tag);
    n_chk++;
    if (count !== ecnt || dir_dn !== edir) begin
      n_fail++;
      $display("FAIL %s count=%0d exp=%0d dir=%0b exp=%0b", tag, count, ecnt, dir_dn, edir);
    end
  endtask

  // Drive one channel change and predict its result
  task automatic step(input logic na, input logic nb, output string tag);
    logic ra, fa, rb, fb, rise_en, fall_en, hit, dn;
    ra = !a && na;  fa = a && !na;
    rb = !b && nb;  fb = b && !nb;
    rise_en = (pol != 2'b01);
    fall_en = (pol != 2'b00);
    hit = 1'b0; dn = 1'b0;
    if (!run) tag = "R9";
    else if (!enc) begin
      tag = "R2";
      hit = (ra && rise_en) || (fa && fall_en);
    end else if ((ra || fa) && (rb || fb)) tag = "R8";
    else begin
      tag = (pol == 2'b00) ? "R3" : (pol == 2'b01) ? "R4" : "R5";
      if      (ra && rise_en) begin hit = 1; dn = nb;  end
      else if (fa && fall_en) begin hit = 1; dn = !nb; end
      else if (rb && rise_en) begin hit = 1; dn = !na; end
      else if (fb && fall_en) begin hit = 1; dn = na;  end
    end
    if (hit) begin
      edir = dn;
      if (dn) begin
        if (ecnt == '0) begin ecnt = ceil; tag = "R7"; end
        else ecnt = ecnt - 1'b1;
      end else begin
        if (ecnt >= ceil) begin ecnt = '0; tag = "R6"; end
        else ecnt = ecnt + 1'b1;
      end
    end
    a = na; b = nb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tag);
  endtask

  task automatic mv(input logic na, input logic nb);
    string t;
    step(na, nb, t);
  endtask

  task automatic set_run(input logic v);
    run = v;
    if (!v) ecnt = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R9");
  endtask

  task automatic config_run(input logic m, input logic [1:0] p, input logic [W-1:0] c);
    set_run(1'b0);
    enc = m; pol = p; ceil = c;
    set_run(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");

    // R2: single-input rising, B ignored
    config_run(1'b0, 2'b00, 16'd100);
    mv(1, 0); mv(0, 0); mv(0, 1); mv(0, 0); mv(1, 1); mv(0, 1);
    // R2: falling and both edges
    config_run(1'b0, 2'b01, 16'd100);
    mv(1, 0); mv(0, 0);
    config_run(1'b0, 2'b10, 16'd100);
    mv(1, 0); mv(0, 0);

    // R5: forward cycle adds 4, reverse cycle subtracts 4
    config_run(1'b1, 2'b10, 16'd1000);
    mv(1, 0); mv(1, 1); mv(0, 1); mv(0, 0);
    mv(0, 1); mv(1, 1); mv(1, 0); mv(0, 0);
    // R10: direction after down then up
    mv(0, 1);
    chk("R10");
    mv(0, 0);
    chk("R10");

    // R8: both channels change together
    mv(1, 1); mv(0, 0);

    // R6/R7: wrap at a small ceiling
    config_run(1'b1, 2'b10, 16'd2);
    mv(0, 1); mv(1, 1);
    mv(1, 0); mv(0, 0); mv(0, 1); mv(1, 1);
    // R3 and R4 single-edge encoder modes
    config_run(1'b1, 2'b00, 16'd50);
    mv(1, 0); mv(1, 1); mv(0, 1); mv(0, 0);
    config_run(1'b1, 2'b01, 16'd50);
    mv(1, 0); mv(1, 1); mv(0, 1); mv(0, 0);

    // R9: edges ignored while stopped
    set_run(1'b0);
    mv(1, 0); mv(1, 1); mv(0, 1);
    set_run(1'b1);

    for (int ph = 0; ph < 30; ph++) begin
      logic [W-1:0] c;
      c = ($urandom_range(0, 7) == 0) ? 16'hFFFF : W'($urandom_range(0, 12));
      config_run(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), c);
      for (int i = 0; i < 40; i++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r == 0)     mv(!a, !b);
        else if (r < 5) mv(!a, b);
        else            mv(a, !b);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule